// File: doc/BRIEF.md
# Serial CRC Generator and Checker

This block computes a cyclic redundancy check one bit per clock by long division of a bit stream by a generator polynomial of degree r, where r is chosen per frame between 1 and 32. The divisor is supplied on input ports at the start of each frame. A shift register of r cells holds the running remainder. Feedback is applied to every cell whose polynomial coefficient is 1, and cell 0 always receives feedback.

In generate mode the caller shifts in the k message bits, most significant first. The block then feeds r zero bits on its own, which is the message multiplied by x^r, and leaves the r-bit remainder to be appended after the data as the frame check sequence. In check mode the caller shifts in a whole received frame of k+r bits. A nonzero remainder is reported as an error, and an all-zero remainder means the frame is accepted. Both modes share the same datapath. A one-cycle done pulse marks the end of every frame.

Top module: `serial_crc_engine`

## Requirements
- R1: After reset, `done` and `error` are 0 and `remainder` is all zeros.
- R2: A high `start` clears the remainder register and the shift counter in the same cycle, and the serial input is not taken in that cycle. A frame that is interrupted by `start` never produces `done`. The next frame's result depends only on its own bits.
- R3: When `checkMode` is 0 at `start`, the block shifts in `msgLen` bits with `bitValid`, most significant first. It then shifts r zeros on consecutive cycles without regard to `bitIn` or `bitValid`. The final `remainder` equals (message · x^r) mod P. For example, data 1010001101 with P = 110101 gives 01110, and data 00111011001 with P = x^4+x^3+1 gives 0100.
- R4: When `checkMode` is 1 at `start`, the block shifts in `msgLen`+r frame bits with `bitValid`, and `remainder` equals frame mod P. The frame 101000110101110 with P = 110101 leaves zero. Flipping one bit of a valid codeword leaves a nonzero remainder.
- R5: Bit i of `polyTaps` is the coefficient of x^i for i < r, and the x^r term is implied. Bit 0 is ignored and always taken as 1. Bits at position r and above are ignored. `polyDegree` gives r, from 1 to 32. `remainder` bits at position r and above read 0.
- R6: While `bitValid` is low during the input phase, no shift happens. A frame fed with gaps gives the same result as one fed without gaps.
- R7: `done` is high for exactly one cycle, in the cycle after the last of the n = `msgLen`+r shifts, once per frame. `remainder` then holds its value until the next `start`, and serial input after `done` is ignored.
- R8: `error` is 1 only while `done` is high, in check mode, with a nonzero remainder. In generate mode it is always 0.
- R9: `checkMode`, `polyDegree`, `polyTaps` and `msgLen` are captured at `start`. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Clears the register and counter and captures the frame configuration |
| checkMode | input | 1 | 0 = generate the check sequence, 1 = check a received frame |
| polyTaps | input | MAX_DEG | Divisor coefficients below the top term |
| polyDegree | input | DEG_W | Divisor degree r (1..MAX_DEG) |
| msgLen | input | LEN_W | Message length k in bits |
| bitIn | input | 1 | Serial data, most significant bit first |
| bitValid | input | 1 | Qualifies `bitIn` during the input phase |
| remainder | output | MAX_DEG | Current remainder, low r bits used |
| done | output | 1 | One-cycle pulse at the end of a frame |
| error | output | 1 | Check-mode nonzero remainder, valid with `done` |

## Verification
The hardest condition to reach from the ports is the generate-mode fill phase running while the serial input carries ones with `bitValid` high. This has to leave the remainder unchanged from the zero-fill result. The bench holds `bitIn` and `bitValid` high through the fill and compares the result with an independent long-division model. A frame is also aborted halfway by a new `start`, and the configuration ports are scrambled mid-frame, to show that neither the aborted bits nor the late configuration reach the result.

// File: rtl/crc_serial_pkg.sv
package crc_serial_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clear;     // zero the register and capture the polynomial
    logic shift;     // advance one bit
    logic zeroFill;  // feed 0 instead of the serial input
  } crcStrobe_t;
endpackage

// File: rtl/crc_serial_ctrl.sv
module crc_serial_ctrl
  import crc_serial_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int DEG_W = 6,
  localparam int CNT_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             checkMode,
  input  logic [DEG_W-1:0] polyDegree,
  input  logic [LEN_W-1:0] msgLen,
  input  logic             bitValid,
  output crcStrobe_t       strobe,
  output logic             done,
  output logic             checkLatched
);
  logic             busy;
  logic [CNT_W-1:0] shiftCnt;
  logic [CNT_W-1:0] frameLen;
  logic [LEN_W-1:0] msgLenL;
  logic             inFill;
  logic             shiftEn;
  logic             lastShift;

  // Generate mode: after the message, zeros are fed on their own
  assign inFill    = !checkLatched && (shiftCnt >= CNT_W'(msgLenL));
  assign shiftEn   = busy && !start && (bitValid || inFill);
  assign lastShift = shiftEn && ((shiftCnt + CNT_W'(1)) == frameLen);

  always_comb begin
    strobe.clear    = start;
    strobe.shift    = shiftEn;
    strobe.zeroFill = inFill;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy         <= 1'b0;
      shiftCnt     <= '0;
      frameLen     <= '0;
      msgLenL      <= '0;
      checkLatched <= 1'b0;
      done         <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy         <= 1'b1;
        shiftCnt     <= '0;
        checkLatched <= checkMode;
        msgLenL      <= msgLen;
        frameLen     <= CNT_W'(msgLen) + CNT_W'(polyDegree);
      end else if (shiftEn) begin
        shiftCnt <= shiftCnt + CNT_W'(1);
        if (lastShift) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/crc_serial_dp.sv
module crc_serial_dp
  import crc_serial_pkg::*;
#(
  parameter int MAX_DEG = 32,
  parameter int DEG_W   = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  crcStrobe_t         strobe,
  input  logic [MAX_DEG-1:0] polyTaps,
  input  logic [DEG_W-1:0]   polyDegree,
  input  logic               bitIn,
  output logic [MAX_DEG-1:0] remainder,
  output logic               remNonZero,
  output logic [DEG_W-1:0]   degLatched
);
  logic [MAX_DEG-1:0] crcReg;
  logic [MAX_DEG-1:0] tapsL;
  logic [MAX_DEG-1:0] cellMask;
  logic [MAX_DEG-1:0] topSel;
  logic [MAX_DEG-1:0] nextReg;
  logic               feedBack;
  logic               inBit;

  assign inBit    = strobe.zeroFill ? 1'b0 : bitIn;
  assign feedBack = |(crcReg & topSel);

  for (genvar i = 0; i < MAX_DEG; i++) begin : g_cell
    assign cellMask[i] = (DEG_W'(i) < degLatched);
    assign topSel[i]   = (degLatched == DEG_W'(i + 1));
    if (i == 0) begin : g_low
      // lowest coefficient is always 1
      assign nextReg[i] = cellMask[i] & (inBit ^ feedBack);
    end else begin : g_up
      assign nextReg[i] = cellMask[i] & (crcReg[i-1] ^ (feedBack & tapsL[i]));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcReg     <= '0;
      tapsL      <= '0;
      degLatched <= '0;
    end else if (strobe.clear) begin
      crcReg     <= '0;
      tapsL      <= polyTaps;
      degLatched <= polyDegree;
    end else if (strobe.shift) begin
      crcReg <= nextReg;
    end
  end

  assign remainder  = crcReg;
  assign remNonZero = |crcReg;
endmodule

// File: rtl/serial_crc_engine.sv
module serial_crc_engine
  import crc_serial_pkg::*;
#(
  parameter int MAX_DEG = 32,
  parameter int LEN_W   = 16,
  localparam int DEG_W  = $clog2(MAX_DEG + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               checkMode,
  input  logic [MAX_DEG-1:0] polyTaps,
  input  logic [DEG_W-1:0]   polyDegree,
  input  logic [LEN_W-1:0]   msgLen,
  input  logic               bitIn,
  input  logic               bitValid,
  output logic [MAX_DEG-1:0] remainder,
  output logic               done,
  output logic               error
);
  crcStrobe_t       strobe;
  logic             checkLatched;
  logic             remNonZero;
  logic [DEG_W-1:0] activeDegree;

  crc_serial_ctrl #(.LEN_W(LEN_W), .DEG_W(DEG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .checkMode(checkMode),
    .polyDegree(polyDegree), .msgLen(msgLen), .bitValid(bitValid),
    .strobe(strobe), .done(done), .checkLatched(checkLatched)
  );

  crc_serial_dp #(.MAX_DEG(MAX_DEG), .DEG_W(DEG_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .polyTaps(polyTaps),
    .polyDegree(polyDegree), .bitIn(bitIn), .remainder(remainder),
    .remNonZero(remNonZero), .degLatched(activeDegree)
  );

  assign error = done & checkLatched & remNonZero;
endmodule

// File: rtl/crc_serial_chk.sv
module crc_serial_chk #(
  parameter int MAX_DEG = 32,
  parameter int DEG_W   = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic               done,
  input logic               error,
  input logic [MAX_DEG-1:0] remainder,
  input logic [DEG_W-1:0]   activeDegree
);
  // R8
  error_needs_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    error |-> done);
  // R8
  error_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    error |-> (remainder != '0));
  // R7
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R7
  rem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> $stable(remainder));
  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (remainder == '0 && !done));
  // R5
  rem_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (remainder >> activeDegree) == '0);
endmodule

bind serial_crc_engine crc_serial_chk #(.MAX_DEG(MAX_DEG), .DEG_W(DEG_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .done(done), .error(error),
  .remainder(remainder), .activeDegree(activeDegree)
);

// File: tb/serial_crc_engine_bench.sv
`timescale 1ns/1ps
module serial_crc_engine_bench;
  localparam int MAX_DEG = 32;
  localparam int LEN_W   = 16;
  localparam int DEG_W   = 6;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               start = 1'b0;
  logic               checkMode = 1'b0;
  logic [MAX_DEG-1:0] polyTaps = '0;
  logic [DEG_W-1:0]   polyDegree = '0;
  logic [LEN_W-1:0]   msgLen = '0;
  logic               bitIn = 1'b0;
  logic               bitValid = 1'b0;
  logic [MAX_DEG-1:0] remainder;
  logic               done;
  logic               error;

  int  checks = 0;
  int  fails = 0;
  int  doneSeen = 0;
  int  doneTarget = 0;
  bit  finished = 1'b0;
  logic [32:0] expQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;  // 125 MHz

  serial_crc_engine #(.MAX_DEG(MAX_DEG), .LEN_W(LEN_W)) u_serial_crc_engine (
    .clk(clk), .rstN(rstN), .start(start), .checkMode(checkMode),
    .polyTaps(polyTaps), .polyDegree(polyDegree), .msgLen(msgLen),
    .bitIn(bitIn), .bitValid(bitValid), .remainder(remainder),
    .done(done), .error(error)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] refMod(logic [63:0] v, int len, logic [31:0] taps, int deg);
    logic [63:0] lowMask;
    logic [63:0] pf;
    lowMask = (64'd1 << deg) - 64'd1;
    pf = (64'd1 << deg) | (64'(taps) & lowMask) | 64'd1;
    for (int i = len - 1; i >= deg; i--)
      if (v[i]) v = v ^ (pf << (i - deg));
    return 32'(v & lowMask);
  endfunction

  // Monitor: pops expectations when done pulses
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (done) begin
        doneSeen++;
        if (expQ.size() == 0) begin
          check(1'b0, "R2/R7 unexpected done", 64'(remainder), 64'd0);
        end else begin
          logic [32:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(remainder == e[31:0], {t, " remainder"}, 64'(remainder), 64'(e[31:0]));
          check(error == e[32], {t, " error"}, 64'(error), 64'(e[32]));
        end
      end else if (error) begin
        check(1'b0, "R8 error without done", 64'(error), 64'd0);
      end
    end
  end

  task automatic pulseStart(input bit chk, input int deg, input logic [31:0] taps, input int k);
    @(negedge clk);
    checkMode  = chk;
    polyDegree = DEG_W'(deg);
    polyTaps   = taps;
    msgLen     = LEN_W'(k);
    start      = 1'b1;
    bitValid   = 1'b1;  // ignored while start is high
    bitIn      = 1'b1;
    @(negedge clk);
    start    = 1'b0;
    bitValid = 1'b0;
  endtask

  // Driver: pushes the expected result, then feeds the frame
  task automatic runFrame(input bit chk, input int deg, input logic [31:0] refTaps,
                          input logic [31:0] dutTaps, input int k, input logic [63:0] data,
                          input int gap, input bit junk, input bit scramble, input string tag,
                          output logic [31:0] rem);
    int len;
    len = chk ? k + deg : k;
    rem = chk ? refMod(data, len, refTaps, deg) : refMod(data << deg, k + deg, refTaps, deg);
    expQ.push_back({chk && (rem != 0), rem});
    tagQ.push_back(tag);
    doneTarget++;
    pulseStart(chk, deg, dutTaps, k);
    if (scramble) begin
      checkMode  = ~chk;
      polyDegree = 6'd3;
      polyTaps   = ~dutTaps;
      msgLen     = 16'd5;
    end
    for (int i = len - 1; i >= 0; i--) begin
      if (gap > 0 && (i % gap) == 0) begin
        bitValid = 1'b0;
        bitIn    = ~data[i];
        @(negedge clk);
      end
      bitValid = 1'b1;
      bitIn    = data[i];
      @(negedge clk);
    end
    bitValid = junk;
    bitIn    = junk;
    while (doneSeen < doneTarget) @(posedge clk);
    @(negedge clk);
    bitValid = 1'b0;
    bitIn    = 1'b0;
  endtask

  initial begin
    logic [31:0] r;
    logic [31:0] saved;
    int dn;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(done == 1'b0, "R1 done", 64'(done), 64'd0);
    check(error == 1'b0, "R1 error", 64'(error), 64'd0);
    check(remainder == '0, "R1 remainder", 64'(remainder), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R3 generate, first vector
    runFrame(1'b0, 5, 32'h15, 32'h15, 10, 64'b1010001101, 0, 1'b0, 1'b0, "R3 vec5", r);
    check(remainder == 32'h0E, "R3 fcs 01110", 64'(remainder), 64'h0E);
    // R4 check of the transmitted frame
    runFrame(1'b1, 5, 32'h15, 32'h15, 10, 64'b101000110101110, 0, 1'b0, 1'b0, "R4 vec5 good", r);
    check(remainder == '0 && error == 1'b0, "R4 zero remainder", 64'(remainder), 64'd0);
    // R3 second vector, degree 4
    runFrame(1'b0, 4, 32'h9, 32'h9, 11, 64'b00111011001, 0, 1'b0, 1'b0, "R3 vec4", r);
    check(remainder == 32'h4, "R3 fcs 0100", 64'(remainder), 64'h4);
    // R4 single flipped bit in the codeword
    runFrame(1'b1, 4, 32'h9, 32'h9, 11, ((64'b00111011001 << 4) | 64'h4) ^ 64'h80,
             0, 1'b0, 1'b0, "R4 vec4 flipped", r);

    // R6 sixteen-bit divisor with gaps in valid
    runFrame(1'b0, 16, 32'h1021, 32'h1021, 32, 64'hC0FFEE11, 3, 1'b0, 1'b0, "R6 ccitt gen gaps", r);
    saved = r;
    runFrame(1'b1, 16, 32'h1021, 32'h1021, 32, (64'hC0FFEE11 << 16) | 64'(saved),
             2, 1'b0, 1'b0, "R6 ccitt check gaps", r);
    runFrame(1'b1, 16, 32'h1021, 32'h1021, 32, ((64'hC0FFEE11 << 16) | 64'(saved)) ^ 64'h4000_0000,
             0, 1'b0, 1'b0, "R4 ccitt flipped", r);

    // R3 serial input held high with valid during the zero fill
    runFrame(1'b0, 16, 32'h8005, 32'h8005, 24, 64'hA5F00D, 0, 1'b1, 1'b0, "R3 crc16 junk fill", r);
    // R5 tap bit 0 cleared and bits above r set in the taps given to the block
    runFrame(1'b0, 16, 32'h8005, 32'hFFFF8004, 24, 64'hA5F00D, 0, 1'b1, 1'b0, "R5 crc16 ignored taps", r);
    // R5 full degree 32
    runFrame(1'b0, 32, 32'h04C11DB7, 32'h04C11DB7, 24, 64'h3C96E1, 0, 1'b0, 1'b0, "R5 deg32", r);

    // R9 configuration scrambled after start
    runFrame(1'b0, 12, 32'h80F, 32'h80F, 20, 64'hBEEF5, 0, 1'b0, 1'b1, "R9 crc12 scrambled", r);

    // R2 abort halfway: no done, next frame clean
    pulseStart(1'b1, 5, 32'h15, 6);
    for (int i = 0; i < 5; i++) begin
      bitValid = 1'b1;
      bitIn    = 1'b1;
      @(negedge clk);
    end
    bitValid = 1'b0;
    runFrame(1'b0, 5, 32'h15, 32'h15, 10, 64'b1010001101, 0, 1'b0, 1'b0, "R2 after abort", r);
    check(remainder == 32'h0E, "R2 fresh result", 64'(remainder), 64'h0E);

    // R7 input after done is ignored
    saved = remainder;
    dn = doneSeen;
    for (int i = 0; i < 8; i++) begin
      bitValid = 1'b1;
      bitIn    = i[0];
      @(negedge clk);
    end
    bitValid = 1'b0;
    repeat (3) @(negedge clk);
    check(remainder == saved, "R7 remainder held", 64'(remainder), 64'(saved));
    check(doneSeen == dn, "R7 no extra done", 64'(doneSeen), 64'(dn));
    check(done == 1'b0 && error == 1'b0, "R8 idle outputs", 64'({done, error}), 64'd0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule